// File: doc/BRIEF.md
# HDLC Receive Byte Queue with Packet-End Tracking

This block buffers received bytes between a bit-level HDLC deframer and a host that reads them one at a time. Each byte the deframer hands over carries a single tag bit. The tag says that the byte closes a packet, whether the packet ended on a closing flag, on an abort or as an invalid frame. The queue holds 128 entries. It tells the host through a look-ahead output whether the byte it is about to read is the final byte of a packet. It also captures the received CRC high byte, in the inverted, MSB-first form the far end sent it, each time a packet closes.

If the deframer tries to push a byte while all 128 entries are occupied, the byte is dropped, an overflow pulse is raised and the receive-enable output drops. The deframer must then stay idle until it reports the next flag, which re-arms reception. If the host has not made room by then, the next push overflows again. A 2-bit selector picks one of four fill levels, and a full indication is raised while occupancy is above the selected level.

Top module: `hdlc_rx_fifo`

## Requirements
- R1: After synchronous reset the queue is empty (`rx_level` = 0), `rx_en` = 1, and `rd_data`, `crc_hi`, `ovf_pulse`, `eop_det`, `full_flag` and `rd_last` are all 0.
- R2: Bytes pushed while `rx_en` = 1 and the queue holds fewer than 128 entries are stored. A read request on a non-empty queue returns the oldest byte on `rd_data` one cycle later. `rx_level` tracks occupancy after each edge.
- R3: A push attempted with `rx_en` = 1 while 128 entries are held is dropped. `ovf_pulse` is high for the following cycle and `rx_en` falls at the same edge.
- R4: While `rx_en` = 0, pushes are ignored and leave occupancy and contents unchanged. A `flag_seen` pulse sets `rx_en` back to 1 from the next cycle.
- R5: After re-arming, a push into a queue that is still holding 128 entries overflows again as in R3.
- R6: `eop_det` is high for one cycle after each stored byte whose tag (`wr_eop`) is 1.
- R7: While the queue is non-empty, `rd_last` equals the tag of the byte at the read head.
- R8: A read request on an empty queue returns 0 on `rd_data` the next cycle and does not advance the read position. Afterwards `rd_last` is 1 until the next stored byte.
- R9: `full_flag` is 1 exactly when occupancy exceeds the level chosen by `thr_sel`: 0 selects 16, 1 selects 48, 2 selects 80, 3 selects 112.
- R10: `crc_hi` takes the value of `wr_crc_hi` at the edge where a byte tagged end-of-packet is stored. It holds its value at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_valid | input | 1 | Deframer pushes a byte this cycle |
| wr_data | input | 8 | Byte from the deframer |
| wr_eop | input | 1 | Byte closes a packet (flag, abort or invalid frame) |
| wr_crc_hi | input | 8 | Received CRC high byte, as sent (inverted, MSB first) |
| flag_seen | input | 1 | Deframer detected a flag; re-arms reception |
| rx_en | output | 1 | Reception enabled; low after an overflow |
| ovf_pulse | output | 1 | One-cycle pulse after a dropped push |
| eop_det | output | 1 | One-cycle pulse after a stored end-of-packet byte |
| crc_hi | output | 8 | CRC high byte latched at the last packet end |
| thr_sel | input | 2 | Full-level selector |
| full_flag | output | 1 | Occupancy above the selected level |
| rx_level | output | 8 | Current occupancy, 0 to 128 |
| rd_req | input | 1 | Host read request |
| rd_data | output | 8 | Byte returned for the previous read request |
| rd_last | output | 1 | Head byte is last of its packet, or the last read found the queue empty |

## Verification
The assertions check on every cycle that occupancy stays within 128, that an overflow pulse follows only a push into a full queue and coincides with reception being off, and that pushes leave occupancy alone while reception is off. They also check that a flag re-arms reception, that packet-end pulses follow only stored tagged bytes, that the CRC byte moves only on such stores, and that empty reads return zero. Only the bench's scenarios can show byte ordering through pointer wrap, the look-ahead tag following the head, a repeated overflow after re-arming without draining, and the exact crossing point of every full level.

// File: rtl/hrf_pkg.sv
package hrf_pkg;

    localparam int HRF_DATA_W = 8;

    typedef struct packed {
        logic                  eop;
        logic [HRF_DATA_W-1:0] data;
    } hrf_entry_t;

    // Full level for selector value sel: odd multiples of depth/8.
    function automatic int unsigned hrf_full_level(input int unsigned sel,
                                                   input int unsigned depth);
        return (depth / 8) * (2 * sel + 1);
    endfunction

    // Next position in a circular buffer of the given depth.
    function automatic int unsigned hrf_wrap_inc(input int unsigned ptr,
                                                 input int unsigned depth);
        return (ptr == depth - 1) ? 0 : ptr + 1;
    endfunction

endpackage

// File: rtl/hrf_store.sv
module hrf_store
    import hrf_pkg::*;
#(
    parameter int DEPTH = 128,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  hrf_entry_t       push_ent,
    input  logic             pop,
    output hrf_entry_t       head,
    output logic [CNT_W-1:0] level
);

    hrf_entry_t       mem [DEPTH];
    logic [PTR_W-1:0] wptr;
    logic [PTR_W-1:0] rptr;

    always_ff @(posedge clk) begin
        if (push) begin
            mem[wptr] <= push_ent;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr  <= '0;
            rptr  <= '0;
            level <= '0;
        end else begin
            if (push) begin
                wptr <= PTR_W'(hrf_wrap_inc(int'(wptr), DEPTH));
            end
            if (pop) begin
                rptr <= PTR_W'(hrf_wrap_inc(int'(rptr), DEPTH));
            end
            case ({push, pop})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end

    assign head = mem[rptr];

endmodule

// File: rtl/hrf_thresh.sv
module hrf_thresh
    import hrf_pkg::*;
#(
    parameter int DEPTH = 128,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int N_LVL = 4
) (
    input  logic [1:0]       sel,
    input  logic [CNT_W-1:0] level,
    output logic             full
);

    logic [CNT_W-1:0] lvl_tab [N_LVL];

    for (genvar g = 0; g < N_LVL; g++) begin : g_lvl
        assign lvl_tab[g] = CNT_W'(hrf_full_level(g, DEPTH));
    end

    assign full = (level > lvl_tab[sel]);

endmodule

// File: rtl/hrf_rxctl.sv
module hrf_rxctl
    import hrf_pkg::*;
#(
    parameter int DEPTH = 128,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_valid,
    input  logic                  wr_eop,
    input  logic [HRF_DATA_W-1:0] wr_crc_hi,
    input  logic                  flag_seen,
    input  logic [CNT_W-1:0]      level,
    output logic                  accept,
    output logic                  rx_en,
    output logic                  ovf_pulse,
    output logic                  eop_det,
    output logic [HRF_DATA_W-1:0] crc_hi
);

    logic attempt;
    logic at_cap;
    logic ovf_now;

    assign attempt = wr_valid & rx_en;
    assign at_cap  = (level == CNT_W'(DEPTH));
    assign accept  = attempt & ~at_cap;
    assign ovf_now = attempt & at_cap;

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_en     <= 1'b1;
            ovf_pulse <= 1'b0;
            eop_det   <= 1'b0;
            crc_hi    <= '0;
        end else begin
            ovf_pulse <= ovf_now;
            eop_det   <= accept & wr_eop;
            if (accept && wr_eop) begin
                crc_hi <= wr_crc_hi;
            end
            if (ovf_now) begin
                rx_en <= 1'b0;
            end else if (flag_seen) begin
                rx_en <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/hdlc_rx_fifo.sv
module hdlc_rx_fifo
    import hrf_pkg::*;
#(
    parameter int DEPTH = 128,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_valid,
    input  logic [HRF_DATA_W-1:0] wr_data,
    input  logic                  wr_eop,
    input  logic [HRF_DATA_W-1:0] wr_crc_hi,
    input  logic                  flag_seen,
    output logic                  rx_en,
    output logic                  ovf_pulse,
    output logic                  eop_det,
    output logic [HRF_DATA_W-1:0] crc_hi,
    input  logic [1:0]            thr_sel,
    output logic                  full_flag,
    output logic [CNT_W-1:0]      rx_level,
    input  logic                  rd_req,
    output logic [HRF_DATA_W-1:0] rd_data,
    output logic                  rd_last
);

    hrf_entry_t head;
    hrf_entry_t push_ent;
    logic       accept;
    logic       empty;
    logic       pop;
    logic       empty_rd_q;

    assign push_ent = '{eop: wr_eop, data: wr_data};
    assign empty    = (rx_level == '0);
    assign pop      = rd_req & ~empty;

    hrf_rxctl #(.DEPTH(DEPTH)) u_ctl (
        .clk       (clk),
        .rst       (rst),
        .wr_valid  (wr_valid),
        .wr_eop    (wr_eop),
        .wr_crc_hi (wr_crc_hi),
        .flag_seen (flag_seen),
        .level     (rx_level),
        .accept    (accept),
        .rx_en     (rx_en),
        .ovf_pulse (ovf_pulse),
        .eop_det   (eop_det),
        .crc_hi    (crc_hi)
    );

    hrf_store #(.DEPTH(DEPTH)) u_store (
        .clk      (clk),
        .rst      (rst),
        .push     (accept),
        .push_ent (push_ent),
        .pop      (pop),
        .head     (head),
        .level    (rx_level)
    );

    hrf_thresh #(.DEPTH(DEPTH)) u_thr (
        .sel   (thr_sel),
        .level (rx_level),
        .full  (full_flag)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data    <= '0;
            empty_rd_q <= 1'b0;
        end else begin
            if (rd_req) begin
                rd_data <= pop ? head.data : '0;
            end
            if (accept) begin
                empty_rd_q <= 1'b0;
            end else if (rd_req && empty) begin
                empty_rd_q <= 1'b1;
            end
        end
    end

    assign rd_last = empty ? empty_rd_q : head.eop;

endmodule

// File: rtl/hdlc_rx_fifo_chk.sv
module hdlc_rx_fifo_chk #(
    parameter int DEPTH = 128,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_valid,
    input logic             wr_eop,
    input logic             flag_seen,
    input logic             rx_en,
    input logic             ovf_pulse,
    input logic             eop_det,
    input logic [7:0]       crc_hi,
    input logic             full_flag,
    input logic [CNT_W-1:0] rx_level,
    input logic             rd_req,
    input logic [7:0]       rd_data
);

    assert_level_bound_R2: assert property (@(posedge clk) disable iff (rst)
        rx_level <= CNT_W'(DEPTH));

    assert_ovf_after_full_R3: assert property (@(posedge clk) disable iff (rst)
        ovf_pulse |-> ($past(rx_level) == CNT_W'(DEPTH) && $past(wr_valid)));

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
        ovf_pulse |-> !rx_en);

    assert_ignore_when_off_R4: assert property (@(posedge clk) disable iff (rst)
        (!rx_en && !rd_req) |=> $stable(rx_level));

    assert_rearm_R4: assert property (@(posedge clk) disable iff (rst)
        (!rx_en && flag_seen) |=> rx_en);

    assert_eop_source_R6: assert property (@(posedge clk) disable iff (rst)
        eop_det |-> $past(wr_valid && wr_eop && rx_en));

    assert_empty_read_R8: assert property (@(posedge clk) disable iff (rst)
        (rd_req && rx_level == '0) |=> (rd_data == 8'h00));

    assert_full_needs_data_R9: assert property (@(posedge clk) disable iff (rst)
        (rx_level == '0) |-> !full_flag);

    assert_crc_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !(wr_valid && wr_eop && rx_en) |=> $stable(crc_hi));

endmodule

bind hdlc_rx_fifo hdlc_rx_fifo_chk #(.DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_valid  (wr_valid),
    .wr_eop    (wr_eop),
    .flag_seen (flag_seen),
    .rx_en     (rx_en),
    .ovf_pulse (ovf_pulse),
    .eop_det   (eop_det),
    .crc_hi    (crc_hi),
    .full_flag (full_flag),
    .rx_level  (rx_level),
    .rd_req    (rd_req),
    .rd_data   (rd_data)
);

// File: tb/hdlc_rx_fifo_bench.sv
module hdlc_rx_fifo_bench;

    localparam int CAP = 128;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_valid = 1'b0;
    logic [7:0] wr_data = '0;
    logic       wr_eop = 1'b0;
    logic [7:0] wr_crc_hi = '0;
    logic       flag_seen = 1'b0;
    logic [1:0] thr_sel = 2'd0;
    logic       rd_req = 1'b0;
    logic       rx_en, ovf_pulse, eop_det, full_flag, rd_last;
    logic [7:0] crc_hi, rd_data, rx_level;

    int checks = 0;
    int errors = 0;

    logic [8:0] q[$];
    bit         m_en  = 1'b1;
    bit         m_erd = 1'b0;
    logic [7:0] m_crc = '0;

    always #5 clk = ~clk;

    hdlc_rx_fifo u_hdlc_rx_fifo (
        .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_data(wr_data),
        .wr_eop(wr_eop), .wr_crc_hi(wr_crc_hi), .flag_seen(flag_seen),
        .rx_en(rx_en), .ovf_pulse(ovf_pulse), .eop_det(eop_det),
        .crc_hi(crc_hi), .thr_sel(thr_sel), .full_flag(full_flag),
        .rx_level(rx_level), .rd_req(rd_req), .rd_data(rd_data),
        .rd_last(rd_last)
    );

    function automatic int full_lvl(input logic [1:0] s);
        case (s)
            2'd0: return 16;
            2'd1: return 48;
            2'd2: return 80;
            default: return 112;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // One clock: drive at negedge, update model, sample at next negedge.
    task automatic cyc(input bit wv, input logic [7:0] wd, input bit we,
                       input logic [7:0] wc, input bit fl, input bit rd);
        int sz;
        bit acc, ovf, rd_ok;
        logic [7:0] exp_rd;
        logic [8:0] junk;
        wr_valid = wv; wr_data = wd; wr_eop = we; wr_crc_hi = wc;
        flag_seen = fl; rd_req = rd;
        sz    = q.size();
        acc   = wv && m_en && (sz != CAP);
        ovf   = wv && m_en && (sz == CAP);
        rd_ok = rd && (sz > 0);
        exp_rd = rd_ok ? q[0][7:0] : 8'h00;
        if (rd_ok) junk = q.pop_front();
        if (acc) q.push_back({we, wd});
        if (acc) m_erd = 1'b0;
        else if (rd && sz == 0) m_erd = 1'b1;
        if (acc && we) m_crc = wc;
        if (ovf) m_en = 1'b0;
        else if (fl) m_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr_valid = 1'b0; flag_seen = 1'b0; rd_req = 1'b0;
        chk(rx_level == q.size(), "R2 level", rx_level, q.size());
        chk(rx_en == m_en, "R4 rx_en", rx_en, m_en);
        chk(ovf_pulse == ovf, "R3 ovf_pulse", ovf_pulse, ovf);
        chk(eop_det == (acc && we), "R6 eop_det", eop_det, acc && we);
        chk(crc_hi == m_crc, "R10 crc_hi", crc_hi, m_crc);
        chk(full_flag == (q.size() > full_lvl(thr_sel)), "R9 full_flag",
            full_flag, q.size() > full_lvl(thr_sel));
        if (q.size() > 0)
            chk(rd_last == q[0][8], "R7 rd_last head", rd_last, q[0][8]);
        else
            chk(rd_last == m_erd, "R8 rd_last empty", rd_last, m_erd);
        if (rd) begin
            if (rd_ok) chk(rd_data == exp_rd, "R2 rd_data", rd_data, exp_rd);
            else       chk(rd_data == 8'h00, "R8 empty read data", rd_data, 0);
        end
    endtask

    task automatic push(input logic [7:0] d, input bit e);
        cyc(1'b1, d, e, ~d, 1'b0, 1'b0);
    endtask

    task automatic pull();
        cyc(1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 1'b1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int unsigned r;
        r = $urandom(32'h5EED_1234);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk(rx_level == 0, "R1 level", rx_level, 0);
        chk(rx_en == 1'b1, "R1 rx_en", rx_en, 1);
        chk(rd_data == 0 && crc_hi == 0, "R1 data/crc", rd_data, 0);
        chk({ovf_pulse, eop_det, full_flag, rd_last} == 4'b0, "R1 flags",
            {ovf_pulse, eop_det, full_flag, rd_last}, 0);

        // R8 empty read on a fresh queue
        pull();
        chk(rd_last == 1'b1, "R8 last after empty read", rd_last, 1);
        // R7 short packets, look-ahead tag
        push(8'hA1, 1'b0); push(8'hA2, 1'b1); push(8'hB1, 1'b1);
        pull(); pull(); pull(); pull();

        // R3/R4/R5 fill to capacity, overflow, ignore, re-arm, overflow again
        thr_sel = 2'd3;
        for (int i = 0; i < CAP; i++) push(8'(i * 3 + 1), (i % 16) == 15);
        push(8'hEE, 1'b1);
        chk(ovf_pulse == 1'b1 && rx_en == 1'b0, "R3 overflow on full",
            {ovf_pulse, rx_en}, 2'b10);
        for (int i = 0; i < 3; i++) push(8'hDD, 1'b1);
        chk(rx_level == CAP, "R4 writes ignored", rx_level, CAP);
        cyc(1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 1'b0);
        chk(rx_en == 1'b1, "R4 re-armed by flag", rx_en, 1);
        push(8'hCC, 1'b0);
        chk(ovf_pulse == 1'b1, "R5 overflow again undrained", ovf_pulse, 1);
        cyc(1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 1'b0);
        // simultaneous read and push at capacity still overflows
        cyc(1'b1, 8'h77, 1'b0, 8'h00, 1'b0, 1'b1);
        cyc(1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 1'b0);
        while (q.size() > 0) pull();
        pull();
        chk(rd_data == 8'h00, "R8 empty read zero", rd_data, 0);
        push(8'h5A, 1'b0);
        chk(rd_last == 1'b0, "R8 cleared by write", rd_last, 0);
        pull();

        // R9 sweep every level up and down
        for (int s = 0; s < 4; s++) begin
            thr_sel = 2'(s);
            for (int i = 0; i < 120; i++) push(8'(i), 1'b0);
            while (q.size() > 0) pull();
        end

        // Constrained random mix
        for (int ph = 0; ph < 3; ph++) begin
            for (int n = 0; n < 1500; n++) begin
                int wp, rp;
                wp = (ph == 0) ? 80 : (ph == 1) ? 50 : 30;
                rp = (ph == 0) ? 20 : (ph == 1) ? 50 : 70;
                if ((n % 200) == 0) thr_sel = 2'($urandom_range(0, 3));
                cyc(($urandom_range(0, 99) < wp), 8'($urandom),
                    ($urandom_range(0, 9) == 0), 8'($urandom),
                    ($urandom_range(0, 19) == 0), ($urandom_range(0, 99) < rp));
            end
        end
        while (q.size() > 0) pull();

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule